// File: doc/BRIEF.md
# UART host register interface

This block is the processor-facing side of one simple serial channel. It sits on an 8-bit register bus with a 6-bit address. Each access lasts one cycle and is qualified by separate read and write strobes. Software uses it to set two mode bytes, issue packed commands that enable or reset the receiver and transmitter, write bytes for transmission, read received bytes from a small queue, and mask the interrupt sources that drive a single level interrupt line.

Bytes to transmit leave on a valid/ready port toward a serializer. That serializer is not part of this block. Received bytes and line-break events arrive on their own input port. Baud generation, bit timing, parity and error detection are outside the block. The two baud-divisor bytes are fixed read-only values set by parameters. The clock-select and auxiliary-control registers accept writes and discard them.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the status reads 0x08, meaning only the transmit-empty flag is set. Both mode bytes read 0x00, and the interrupt status and the mask are zero. The transmitter and the receiver are disabled, so `irq`, `tx_valid` and `rx_ready` are low.
- R2: A write to offset 0x00 stores into the mode byte that the pointer selects, then moves the pointer to the second mode byte. A read of 0x00 returns the selected byte. The command miscellaneous code 1 moves the pointer back to the first byte.
- R3: Command bits [3:2] control the transmitter: 1 enables it, 2 disables it, and 0 or 3 have no effect. Miscellaneous code 3 (command bits [6:4]) disables the transmitter, discards any held byte and sets transmit-empty. Within one command the field in bits [3:2] is applied after the miscellaneous field. Status bit 2 (transmit-ready) equals the transmitter enable.
- R4: Command bits [1:0] control the receiver with the same 1 and 2 codes. Miscellaneous code 2 disables the receiver and empties the receive queue, which clears status bits 0 and 1. The receiver field is applied after the miscellaneous field.
- R5: A write to offset 0x0C loads the transmit holding byte and clears status bit 3 (transmit-empty). While the transmitter is enabled, the byte is presented on `tx_data` with `tx_valid`. It holds there until `tx_ready` is seen, and then transmit-empty is set again. A byte written while the transmitter is disabled stays held and is released when the transmitter is enabled.
- R6: While enabled and not full, the receiver accepts bytes on `rx_valid`/`rx_ready` into a queue of 4 entries. Reads of offset 0x0C return the bytes oldest first and remove them. Status bit 0 shows that the queue is not empty and bit 1 shows that it is full. `rx_ready` is low when the receiver is disabled or the queue is full. A read of an empty queue returns 0x00 and changes nothing.
- R7: A pulse on `rx_break` sets interrupt status bit 2 and enqueues 0x00, even when the receiver is disabled. When the queue is full, the 0x00 replaces the newest entry. Miscellaneous code 5 clears the break flag.
- R8: Interrupt status (read at 0x14) bit 0 is transmit-ready. Bit 1 is queue-full when bit 6 of the first mode byte is set, and queue-not-empty otherwise. Bit 2 is the break flag. A write to 0x14 sets the mask. `irq` is high when any masked status bit is set.
- R9: Writes to offset 0x04, offset 0x10 and any unmapped offset change nothing. Reads of 0x18 and 0x1C return the parameter values `DIV_HI` and `DIV_LO`. All other unmapped reads, and reads of 0x08 and 0x10, return 0. Status bits 7:4 read 0.
- R10: A read of offset 0x0C removes a byte only in a cycle where `bus_rd` is high. Holding the address without the strobe leaves the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read side effects take place on the edge that ends this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, decoded combinationally from `bus_addr` |
| irq | output | 1 | Level interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receiver accepts a byte this cycle |
| rx_break | input | 1 | Line-break event pulse |

## Verification
Assertions check, on every cycle, the rules that relate one step to the next. The pointer advances after each mode write and returns after a pointer reset. Reset commands take effect on the next cycle, and a break always sets its flag. The queue count never passes its depth, and no byte is accepted while the queue is full. A held transmit byte stays stable until it is accepted, and ignored writes leave the state untouched. Some behaviour can only be shown by the bench's scenarios, which compare observed values against a model. These cases are:
- the oldest-first order of queued bytes
- the break byte replacing the newest entry
- the field order inside one command byte
- release of a byte written while the transmitter was disabled
- dropping of a held byte by transmitter reset
- the switch of the receive interrupt source by mode bit 6
- the exact register values read at each offset

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int MODE_RXSEL_BIT = 6;

  localparam logic [AW-1:0] OFS_MODE = 6'h00;
  localparam logic [AW-1:0] OFS_STAT = 6'h04;
  localparam logic [AW-1:0] OFS_CMD  = 6'h08;
  localparam logic [AW-1:0] OFS_DATA = 6'h0C;
  localparam logic [AW-1:0] OFS_AUX  = 6'h10;
  localparam logic [AW-1:0] OFS_INT  = 6'h14;
  localparam logic [AW-1:0] OFS_DIVH = 6'h18;
  localparam logic [AW-1:0] OFS_DIVL = 6'h1C;

  typedef enum logic [2:0] {
    MC_NONE    = 3'd0,
    MC_PTR_RST = 3'd1,
    MC_RX_RST  = 3'd2,
    MC_TX_RST  = 3'd3,
    MC_ERR_RST = 3'd4,
    MC_BRK_CLR = 3'd5,
    MC_BRK_ON  = 3'd6,
    MC_BRK_OFF = 3'd7
  } misc_code_e;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_ON   = 2'd1,
    EN_OFF  = 2'd2,
    EN_RSVD = 2'd3
  } en_code_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;

  function automatic logic [DW-1:0] pack_status(input logic not_empty, input logic full,
                                                input logic tx_rdy, input logic tx_emp);
    return {4'b0000, tx_emp, tx_rdy, full, not_empty};
  endfunction

  function automatic logic rx_irq_source(input logic sel_full, input logic not_empty,
                                         input logic full);
    return sel_full ? full : not_empty;
  endfunction

  function automatic logic [DW-1:0] pack_isr(input logic tx_src, input logic rx_src,
                                             input logic brk);
    return {5'b00000, brk, rx_src, tx_src};
  endfunction

  function automatic logic next_enable(input logic cur, input logic on, input logic off,
                                       input logic rst);
    if (on)       return 1'b1;
    else if (off) return 1'b0;
    else if (rst) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_host_pkg::*;
(
  input  logic       valid,
  input  logic [6:0] cmd,
  output cmd_act_t   act
);
  misc_code_e misc;
  en_code_e   txf;
  en_code_e   rxf;

  always_comb begin
    misc = misc_code_e'(cmd[6:4]);
    txf  = en_code_e'(cmd[3:2]);
    rxf  = en_code_e'(cmd[1:0]);
    act.ptr_rst = valid && (misc == MC_PTR_RST);
    act.rx_rst  = valid && (misc == MC_RX_RST);
    act.tx_rst  = valid && (misc == MC_TX_RST);
    act.brk_clr = valid && (misc == MC_BRK_CLR);
    act.tx_on   = valid && (txf == EN_ON);
    act.tx_off  = valid && (txf == EN_OFF);
    act.rx_on   = valid && (rxf == EN_ON);
    act.rx_off  = valid && (rxf == EN_OFF);
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push_byte,
  input  logic [W-1:0] push_data,
  input  logic         push_brk,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_mid, cnt_d, wr_pos;
  logic          pop_ok, do_push, at_cap;

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    cnt_mid = cnt_q - CW'(pop_ok);
    do_push = push_byte || push_brk;
    at_cap  = (cnt_mid == CAP);
    wr_pos  = at_cap ? CW'(DEPTH - 1) : cnt_mid;
    for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = pop_ok ? mem_q[i+1] : mem_q[i];
    mem_d[DEPTH-1] = mem_q[DEPTH-1];
    for (int i = 0; i < DEPTH; i++)
      if (do_push && (wr_pos == CW'(i))) mem_d[i] = push_brk ? '0 : push_data;
    if (flush)        cnt_d = '0;
    else if (do_push) cnt_d = at_cap ? cnt_mid : cnt_mid + 1'b1;
    else              cnt_d = cnt_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign head  = mem_q[0];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CAP);

  // R6
  rxq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CAP);
  // R6
  rxq_no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_byte |-> (cnt_q != CAP));
  // R4
  rxq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty);
  // R10
  rxq_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !do_push && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         drop,
  input  logic         enable,
  input  logic         out_ready,
  output logic         pend,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         pend_q;
  logic [W-1:0] data_q;
  logic         taken;

  assign taken = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) data_q <= load_data;
      if (drop)       pend_q <= 1'b0;
      else if (load)  pend_q <= 1'b1;
      else if (taken) pend_q <= 1'b0;
    end
  end

  assign pend      = pend_q;
  assign out_valid = pend_q && enable;
  assign out_data  = data_q;

  // R5
  txh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !taken && !load && !drop) |=> (pend_q && $stable(data_q)));
  // R5
  txh_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !load) |=> !pend_q);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int          RXQ_DEPTH = 4,
  parameter logic [7:0]  DIV_HI    = 8'h12,
  parameter logic [7:0]  DIV_LO    = 8'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          rx_break
);
  logic [DW-1:0] mode_a, mode_b, imr;
  logic          mode_ptr, tx_en, rx_en, brk_flag;
  logic          wr_mode, wr_cmd, wr_data, wr_int, rd_pop;
  cmd_act_t      act;
  logic [DW-1:0] rxq_head;
  logic          rxq_empty, rxq_full, tx_pend;
  logic [DW-1:0] status, isr;

  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_int  = bus_wr && (bus_addr == OFS_INT);
  assign rd_pop  = bus_rd && (bus_addr == OFS_DATA);

  uart_cmd_decode u_cmd (
    .valid (wr_cmd),
    .cmd   (bus_wdata[6:0]),
    .act   (act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a   <= '0;
      mode_b   <= '0;
      mode_ptr <= 1'b0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      brk_flag <= 1'b0;
      imr      <= '0;
    end else begin
      if (wr_mode) begin
        if (mode_ptr) mode_b <= bus_wdata;
        else          mode_a <= bus_wdata;
        mode_ptr <= 1'b1;
      end else if (act.ptr_rst) begin
        mode_ptr <= 1'b0;
      end
      tx_en <= next_enable(tx_en, act.tx_on, act.tx_off, act.tx_rst);
      rx_en <= next_enable(rx_en, act.rx_on, act.rx_off, act.rx_rst);
      if (rx_break)          brk_flag <= 1'b1;
      else if (act.brk_clr)  brk_flag <= 1'b0;
      if (wr_int) imr <= bus_wdata;
    end
  end

  assign rx_ready = rx_en && !rxq_full && !rx_break;

  uart_rx_queue #(.DEPTH(RXQ_DEPTH), .W(DW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (act.rx_rst),
    .push_byte (rx_valid && rx_ready),
    .push_data (rx_data),
    .push_brk  (rx_break),
    .pop       (rd_pop),
    .head      (rxq_head),
    .empty     (rxq_empty),
    .full      (rxq_full)
  );

  uart_tx_hold #(.W(DW)) u_txh (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_data (bus_wdata),
    .drop      (act.tx_rst),
    .enable    (tx_en),
    .out_ready (tx_ready),
    .pend      (tx_pend),
    .out_valid (tx_valid),
    .out_data  (tx_data)
  );

  assign status = pack_status(!rxq_empty, rxq_full, tx_en, !tx_pend);
  assign isr    = pack_isr(tx_en,
                           rx_irq_source(mode_a[MODE_RXSEL_BIT], !rxq_empty, rxq_full),
                           brk_flag);
  assign irq    = |(isr & imr);

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_ptr ? mode_b : mode_a;
      OFS_STAT: bus_rdata = status;
      OFS_DATA: bus_rdata = rxq_empty ? '0 : rxq_head;
      OFS_INT:  bus_rdata = isr;
      OFS_DIVH: bus_rdata = DIV_HI;
      OFS_DIVL: bus_rdata = DIV_LO;
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  mode_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_mode |=> mode_ptr);
  // R2
  mode_ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.ptr_rst |=> !mode_ptr);
  // R3
  tx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act.tx_rst && !act.tx_on) |=> (!tx_en && !tx_pend));
  // R4
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act.rx_rst && !act.rx_on) |=> (!rx_en && rxq_empty));
  // R7
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_break |=> brk_flag);
  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imr != '0));
  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_STAT || bus_addr == OFS_AUX))
      |=> $stable({mode_a, mode_b, mode_ptr, tx_en, rx_en, imr}));
endmodule

// File: tb/uart_host_regs_tb.sv
`timescale 1ns/1ps
module uart_host_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, tx_valid, rx_ready;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  always #10 clk = ~clk;

  uart_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_break(rx_break)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] mask,
                        input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    check(req, int'(v & mask), int'(exp));
  endtask

  task automatic rx_pop_chk(input string req);
    logic [7:0] v;
    logic [7:0] e;
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
    bus_read(6'h0C, v);
    check(req, int'(v), int'(e));
  endtask

  task automatic rx_send(input logic [7:0] d, input logic exp_acc, input string req);
    logic acc;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    #2 acc = rx_ready;
    @(posedge clk); #1 rx_valid = 1'b0;
    check(req, int'(acc), int'(exp_acc));
    if (acc) exp_rx.push_back(d);
  endtask

  task automatic brk_pulse();
    @(negedge clk);
    rx_break = 1'b1;
    @(posedge clk); #1 rx_break = 1'b0;
    if (exp_rx.size() == 4) void'(exp_rx.pop_back());
    exp_rx.push_back(8'h00);
  endtask

  task automatic sig_chk(input string req, input logic s, input logic e);
    @(negedge clk);
    #2 check(req, int'(s), int'(e));
  endtask

  // scoreboard monitor for the transmit port (R5)
  always @(negedge clk) begin
    #5;
    if (rst_n && tx_valid && tx_ready) begin
      n_chk++;
      if (exp_tx.size() == 0) begin
        n_fail++;
        $display("FAIL R5: unexpected tx byte %0h expected none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        if (tx_data != e) begin
          n_fail++;
          $display("FAIL R5: tx byte actual %0h expected %0h", tx_data, e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 status", 6'h04, 8'hFF, 8'h08);
    rd_chk("R1 mode", 6'h00, 8'hFF, 8'h00);
    rd_chk("R1 isr", 6'h14, 8'hFF, 8'h00);
    sig_chk("R1 irq", irq, 1'b0);
    sig_chk("R1 tx_valid", tx_valid, 1'b0);
    sig_chk("R1 rx_ready", rx_ready, 1'b0);

    // R2 mode pointer
    bus_write(6'h00, 8'hA5);
    bus_write(6'h00, 8'h3C);
    rd_chk("R2 second mode", 6'h00, 8'hFF, 8'h3C);
    bus_write(6'h08, 8'h10);
    rd_chk("R2 first after ptr reset", 6'h00, 8'hFF, 8'hA5);
    bus_write(6'h00, 8'h5A);
    rd_chk("R2 ptr advanced", 6'h00, 8'hFF, 8'h3C);
    bus_write(6'h08, 8'h10);
    rd_chk("R2 first rewritten", 6'h00, 8'hFF, 8'h5A);

    // R9 ignored writes and fixed reads
    bus_write(6'h04, 8'hFF);
    bus_write(6'h10, 8'hFF);
    bus_write(6'h24, 8'hFF);
    bus_write(6'h3C, 8'hFF);
    rd_chk("R9 status unchanged", 6'h04, 8'hFF, 8'h08);
    rd_chk("R9 mode unchanged", 6'h00, 8'hFF, 8'h5A);
    rd_chk("R9 aux reads 0", 6'h10, 8'hFF, 8'h00);
    rd_chk("R9 div hi", 6'h18, 8'hFF, 8'h12);
    rd_chk("R9 div lo", 6'h1C, 8'hFF, 8'h34);
    rd_chk("R9 cmd reads 0", 6'h08, 8'hFF, 8'h00);
    rd_chk("R9 unmapped reads 0", 6'h3C, 8'hFF, 8'h00);
    sig_chk("R9 irq", irq, 1'b0);

    // R5 transmit path
    bus_write(6'h0C, 8'h77);
    rd_chk("R5 txemp cleared", 6'h04, 8'hFF, 8'h00);
    sig_chk("R5 held while disabled", tx_valid, 1'b0);
    bus_write(6'h08, 8'h04);
    rd_chk("R3 enable sets txrdy", 6'h04, 8'hFF, 8'h04);
    sig_chk("R5 released on enable", tx_valid, 1'b1);
    repeat (3) @(posedge clk);
    sig_chk("R5 held without ready", tx_valid, 1'b1);
    @(negedge clk); #2 check("R5 held data", int'(tx_data), 8'h77);
    exp_tx.push_back(8'h77);
    @(negedge clk); tx_ready = 1'b1;
    repeat (2) @(posedge clk);
    rd_chk("R5 txemp after send", 6'h04, 8'hFF, 8'h0C);
    exp_tx.push_back(8'h99);
    bus_write(6'h0C, 8'h99);
    exp_tx.push_back(8'hC3);
    bus_write(6'h0C, 8'hC3);
    repeat (2) @(posedge clk);
    rd_chk("R5 back to empty", 6'h04, 8'hFF, 8'h0C);

    // R3 transmitter commands
    bus_write(6'h08, 8'h0C);
    rd_chk("R3 field 3 no effect", 6'h04, 8'hFF, 8'h0C);
    bus_write(6'h08, 8'h08);
    rd_chk("R3 disable", 6'h04, 8'hFF, 8'h08);
    bus_write(6'h08, 8'h00);
    rd_chk("R3 field 0 no effect", 6'h04, 8'hFF, 8'h08);
    @(negedge clk); tx_ready = 1'b0;
    bus_write(6'h08, 8'h04);
    bus_write(6'h0C, 8'h55);
    rd_chk("R3 pending", 6'h04, 8'hFF, 8'h04);
    bus_write(6'h08, 8'h30);
    rd_chk("R3 tx reset", 6'h04, 8'hFF, 8'h08);
    sig_chk("R3 tx reset drops valid", tx_valid, 1'b0);
    bus_write(6'h08, 8'h04);
    rd_chk("R3 re-enable", 6'h04, 8'hFF, 8'h0C);
    sig_chk("R3 dropped byte stays dropped", tx_valid, 1'b0);
    bus_write(6'h0C, 8'h66);
    bus_write(6'h08, 8'h08);
    rd_chk("R5 disabled with pending", 6'h04, 8'hFF, 8'h00);
    sig_chk("R5 no valid while disabled", tx_valid, 1'b0);
    exp_tx.push_back(8'h66);
    @(negedge clk); tx_ready = 1'b1;
    bus_write(6'h08, 8'h04);
    repeat (2) @(posedge clk);
    rd_chk("R5 late release done", 6'h04, 8'hFF, 8'h0C);
    bus_write(6'h08, 8'h30);
    rd_chk("R3 reset only", 6'h04, 8'hFF, 8'h08);
    bus_write(6'h08, 8'h34);
    rd_chk("R3 field after misc", 6'h04, 8'hFF, 8'h0C);

    // R6 receive queue
    rx_send(8'hE1, 1'b0, "R6 rejected when disabled");
    rd_chk("R6 empty", 6'h04, 8'h03, 8'h00);
    bus_write(6'h08, 8'h01);
    sig_chk("R6 ready when enabled", rx_ready, 1'b1);
    rx_send(8'h11, 1'b1, "R6 accept");
    rx_send(8'h22, 1'b1, "R6 accept");
    rx_send(8'h33, 1'b1, "R6 accept");
    rd_chk("R6 not empty", 6'h04, 8'h03, 8'h01);
    rx_send(8'h44, 1'b1, "R6 accept");
    rd_chk("R6 full", 6'h04, 8'h03, 8'h03);
    rx_send(8'h55, 1'b0, "R6 rejected when full");
    // R10 address without strobe does not pop
    @(negedge clk); bus_addr = 6'h0C;
    repeat (3) @(posedge clk);
    @(negedge clk); #2 check("R10 peek", int'(bus_rdata), 8'h11);
    rd_chk("R10 still full", 6'h04, 8'h03, 8'h03);
    rx_pop_chk("R6 order");
    rd_chk("R6 full cleared", 6'h04, 8'h03, 8'h01);
    rx_pop_chk("R6 order");
    rx_pop_chk("R6 order");
    rx_pop_chk("R6 order");
    rd_chk("R6 drained", 6'h04, 8'h03, 8'h00);
    rx_pop_chk("R6 empty read 0");
    rd_chk("R6 empty read no effect", 6'h04, 8'h03, 8'h00);

    // R7 break
    rx_send(8'h01, 1'b1, "R7 fill");
    rx_send(8'h02, 1'b1, "R7 fill");
    rx_send(8'h03, 1'b1, "R7 fill");
    rx_send(8'h04, 1'b1, "R7 fill");
    brk_pulse();
    rd_chk("R7 break flag", 6'h14, 8'h04, 8'h04);
    rx_pop_chk("R7 overwrite");
    rx_pop_chk("R7 overwrite");
    rx_pop_chk("R7 overwrite");
    rx_pop_chk("R7 overwrite newest");
    bus_write(6'h08, 8'h02);
    brk_pulse();
    rd_chk("R7 break while disabled", 6'h04, 8'h01, 8'h01);
    rx_pop_chk("R7 break byte");
    bus_write(6'h08, 8'h50);
    rd_chk("R7 flag cleared", 6'h14, 8'h04, 8'h00);

    // R8 interrupt sources and mask
    bus_write(6'h08, 8'h10);
    bus_write(6'h00, 8'h00);
    bus_write(6'h08, 8'h01);
    bus_write(6'h14, 8'h02);
    rx_send(8'hAA, 1'b1, "R8 fill");
    rd_chk("R8 rx src ready", 6'h14, 8'h02, 8'h02);
    sig_chk("R8 irq ready", irq, 1'b1);
    bus_write(6'h08, 8'h10);
    bus_write(6'h00, 8'h40);
    rd_chk("R8 rx src full", 6'h14, 8'h02, 8'h00);
    sig_chk("R8 irq low", irq, 1'b0);
    rx_send(8'hBB, 1'b1, "R8 fill");
    rx_send(8'hCC, 1'b1, "R8 fill");
    rx_send(8'hDD, 1'b1, "R8 fill");
    rd_chk("R8 full source", 6'h14, 8'h02, 8'h02);
    sig_chk("R8 irq on full", irq, 1'b1);
    bus_write(6'h14, 8'h00);
    sig_chk("R8 masked", irq, 1'b0);
    bus_write(6'h14, 8'h01);
    sig_chk("R8 tx source", irq, 1'b1);
    rd_chk("R8 isr bit0", 6'h14, 8'h01, 8'h01);
    bus_write(6'h14, 8'h00);

    // R4 receiver reset
    bus_write(6'h08, 8'h20);
    exp_rx.delete();
    rd_chk("R4 queue emptied", 6'h04, 8'h03, 8'h00);
    sig_chk("R4 disabled", rx_ready, 1'b0);
    rx_pop_chk("R4 read after reset");
    bus_write(6'h08, 8'h21);
    sig_chk("R4 field after misc", rx_ready, 1'b1);
    rx_send(8'h5E, 1'b1, "R4 accept");
    rx_pop_chk("R4 data");

    repeat (5) @(posedge clk);
    check("R5 all tx bytes seen", exp_tx.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule